// File: doc/BRIEF.md
# Receive DMA Write Burst Splitter

This block takes one receive DMA write request, given as a start byte address and a byte length, and cuts it into a sequence of bus write bursts. For each burst it chooses between a plain Memory Write and a Memory Write and Invalidate. Each burst is handed downstream as a descriptor. A descriptor carries the bus command code, the burst start address, a DWORD count, the byte enables for the burst's final DWORD, and a flag that marks a burst which stops exactly on a cache line boundary.

A burst always runs from the current address to whichever comes first: the next cache line boundary or the end of the request. As a result, a misaligned request yields three kinds of bursts in order. First a plain head that runs up to the first boundary, then one burst per whole line, then a plain partial tail. The choice of invalidate is made again for every line. It depends on the configured line size, the alignment, the bytes still to write, the receive FIFO fill level and an enable bit in the supplied command register word. If any condition lapses, the next line falls back to a plain write. An invalidate burst never extends past its own line.

Descriptors leave through a valid/ready handshake. A one-cycle done pulse follows the acceptance of the last descriptor.

Top module: `dma_wr_splitter`

## Requirements
- R1: After reset, req_ready is 1, and desc_valid and done are 0.
- R2: A burst uses command code 4'b1111 (write and invalidate) only when all of the following hold: cfg_line_dw is 8 or 16, the burst address is aligned to a line, at least one full line of bytes remains, fifo_level is at least the line size in DWORDs, and cfg_cmd bit 4 is 1. Otherwise the burst uses code 4'b0111 (plain write).
- R3: An invalidate burst is exactly one line long, starts on a line boundary, has desc_be = 4'b1111 and has desc_line_end = 1.
- R4: Each burst spans from the current address to the nearer of the next line boundary or the request end. desc_dwords is never 0, and successive bursts are contiguous.
- R5: When cfg_line_dw is neither 8 nor 16, every burst is a plain write, and boundaries fall every DEF_CHUNK_DW DWORDs (16 by default).
- R6: desc_be (bit 0 is the lowest byte) applies to the burst's final DWORD. It is 4'b1111 unless that DWORD is the last one of the request. In that case a remainder of length mod 4 equal to 1, 2 or 3 gives 4'b0001, 4'b0011 or 4'b0111.
- R7: While desc_valid is 1 and desc_ready is 0, all descriptor outputs stay stable. Input changes made during that wait affect only later descriptors.
- R8: done is high for exactly one cycle after the last descriptor is accepted. A zero-length request produces done and no descriptor.
- R9: desc_line_end is 1 exactly when the burst's last DWORD is the last DWORD of a line.
- R10: req_ready is 1 only when the block is idle. Requests presented while it is busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and accepting a request |
| req_addr | input | AW | Request start byte address (DWORD aligned) |
| req_len | input | LW | Request length in bytes |
| cfg_line_dw | input | 8 | Configured cache line size in DWORDs |
| cfg_cmd | input | CMD_W | Command register word; bit MWI_EN_BIT enables invalidate |
| fifo_level | input | FW | Receive FIFO fill level in DWORDs |
| desc_valid | output | 1 | Descriptor present |
| desc_ready | input | 1 | Downstream accepts the descriptor |
| desc_cmd | output | 4 | Bus command code |
| desc_addr | output | AW | Burst start byte address |
| desc_dwords | output | CNT_W | Burst length in DWORDs |
| desc_be | output | 4 | Byte enables of the burst's final DWORD |
| desc_line_end | output | 1 | Burst ends on a cache line boundary |
| done | output | 1 | One-cycle pulse after the last burst is taken |

## Verification
Two things can land in the same cycle: a descriptor being held back by a stalled handshake, and a change to the inputs that decide the next line's command. The bench provokes this by stalling desc_ready while an invalidate descriptor is pending and dropping the FIFO level during the stall. It then judges that the held descriptor keeps its invalidate code and fields unchanged, and that the following line, computed after the drop, comes out as a plain write.

// File: rtl/dws_pkg.sv
package dws_pkg;
   typedef enum logic [3:0] {
      CMD_MW  = 4'b0111,
      CMD_MWI = 4'b1111
   } bus_cmd_e;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_PREP,
      ST_SEND,
      ST_DONE
   } split_state_e;
endpackage

// File: rtl/dws_line_cfg.sv
module dws_line_cfg #(
   parameter int DEF_CHUNK_DW = 16,
   parameter int CNT_W        = 5
) (
   input  logic [7:0]       cfg_line_dw,
   output logic [CNT_W-1:0] line_dw,
   output logic             size_ok
);
   always_comb begin
      size_ok = (cfg_line_dw == 8'd8) || (cfg_line_dw == 8'd16);
      if (size_ok) line_dw = CNT_W'(cfg_line_dw);
      else         line_dw = CNT_W'(DEF_CHUNK_DW);
   end
endmodule

// File: rtl/dws_cmd_sel.sv
module dws_cmd_sel #(
   parameter int LW        = 16,
   parameter int FW        = 8,
   parameter int CNT_W     = 5,
   parameter bit ALLOW_MWI = 1'b1
) (
   input  logic [CNT_W-2:0] addr_dw_lo,
   input  logic [LW-1:0]    rem_bytes,
   input  logic [CNT_W-1:0] line_dw,
   input  logic             size_ok,
   input  logic [FW-1:0]    fifo_level,
   input  logic             mwi_en,
   output logic [CNT_W-1:0] cnt,
   output logic             is_mwi,
   output logic [3:0]       be,
   output logic             end_line
);
   logic [CNT_W-1:0] off_dw;
   logic [CNT_W-1:0] to_bnd;
   logic [LW-1:0]    rem_dw;
   logic [LW-1:0]    line_bytes;
   logic             last_chunk;

   always_comb begin
      off_dw     = {1'b0, addr_dw_lo} & (line_dw - 1'b1);
      to_bnd     = line_dw - off_dw;
      rem_dw     = {2'b00, rem_bytes[LW-1:2]} + LW'(|rem_bytes[1:0]);
      line_bytes = LW'({line_dw, 2'b00});
      last_chunk = rem_dw <= LW'(to_bnd);
      cnt        = last_chunk ? rem_dw[CNT_W-1:0] : to_bnd;
      end_line   = (cnt == to_bnd);
      be         = 4'b1111;
      if (last_chunk) begin
         case (rem_bytes[1:0])
            2'd1:    be = 4'b0001;
            2'd2:    be = 4'b0011;
            2'd3:    be = 4'b0111;
            default: be = 4'b1111;
         endcase
      end
   end

   generate
      if (ALLOW_MWI) begin : g_mwi
         assign is_mwi = size_ok && (off_dw == '0) && (rem_bytes >= line_bytes)
                         && (fifo_level >= FW'(line_dw)) && mwi_en;
      end else begin : g_mw_only
         assign is_mwi = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dma_wr_splitter.sv
module dma_wr_splitter #(
   parameter int AW           = 32,
   parameter int LW           = 16,
   parameter int FW           = 8,
   parameter int CMD_W        = 16,
   parameter int MWI_EN_BIT   = 4,
   parameter int DEF_CHUNK_DW = 16,
   parameter int CNT_W        = 5,
   parameter bit ALLOW_MWI    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   output logic             req_ready,
   input  logic [AW-1:0]    req_addr,
   input  logic [LW-1:0]    req_len,
   input  logic [7:0]       cfg_line_dw,
   input  logic [CMD_W-1:0] cfg_cmd,
   input  logic [FW-1:0]    fifo_level,
   output logic             desc_valid,
   input  logic             desc_ready,
   output logic [3:0]       desc_cmd,
   output logic [AW-1:0]    desc_addr,
   output logic [CNT_W-1:0] desc_dwords,
   output logic [3:0]       desc_be,
   output logic             desc_line_end,
   output logic             done
);
   import dws_pkg::*;

   localparam int MAXL = (DEF_CHUNK_DW > 16) ? DEF_CHUNK_DW : 16;

   generate
      if (CNT_W < $clog2(MAXL + 1)) begin : g_bad_cnt
         $error("CNT_W too narrow for the largest burst");
      end
      if ((DEF_CHUNK_DW < 1) || ((DEF_CHUNK_DW & (DEF_CHUNK_DW - 1)) != 0)) begin : g_bad_chunk
         $error("DEF_CHUNK_DW must be a power of two");
      end
      if ((LW < CNT_W + 3) || (AW <= CNT_W) || (FW < CNT_W)) begin : g_bad_width
         $error("address, length or level width too small");
      end
      if (MWI_EN_BIT >= CMD_W) begin : g_bad_bit
         $error("MWI_EN_BIT outside cfg_cmd");
      end
   endgenerate

   split_state_e     state;
   bus_cmd_e         cmd_r;
   logic [AW-1:0]    cur_addr;
   logic [LW-1:0]    rem_bytes;
   logic [CNT_W-1:0] line_dw;
   logic             size_ok;
   logic [CNT_W-1:0] nxt_cnt;
   logic             nxt_mwi;
   logic [3:0]       nxt_be;
   logic             nxt_end;
   logic [LW-1:0]    sent_bytes;
   logic             unused_cmd;

   assign unused_cmd = ^cfg_cmd;

   dws_line_cfg #(.DEF_CHUNK_DW(DEF_CHUNK_DW), .CNT_W(CNT_W)) u_line (
      .cfg_line_dw (cfg_line_dw),
      .line_dw     (line_dw),
      .size_ok     (size_ok)
   );

   dws_cmd_sel #(.LW(LW), .FW(FW), .CNT_W(CNT_W), .ALLOW_MWI(ALLOW_MWI)) u_sel (
      .addr_dw_lo (cur_addr[CNT_W:2]),
      .rem_bytes  (rem_bytes),
      .line_dw    (line_dw),
      .size_ok    (size_ok),
      .fifo_level (fifo_level),
      .mwi_en     (cfg_cmd[MWI_EN_BIT]),
      .cnt        (nxt_cnt),
      .is_mwi     (nxt_mwi),
      .be         (nxt_be),
      .end_line   (nxt_end)
   );

   assign sent_bytes = LW'({desc_dwords, 2'b00});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state         <= ST_IDLE;
         cmd_r         <= CMD_MW;
         cur_addr      <= '0;
         rem_bytes     <= '0;
         desc_addr     <= '0;
         desc_dwords   <= '0;
         desc_be       <= '0;
         desc_line_end <= 1'b0;
      end else begin
         case (state)
            ST_IDLE: if (req_valid) begin
               cur_addr  <= req_addr;
               rem_bytes <= req_len;
               state     <= (req_len == '0) ? ST_DONE : ST_PREP;
            end
            ST_PREP: begin
               cmd_r         <= nxt_mwi ? CMD_MWI : CMD_MW;
               desc_addr     <= cur_addr;
               desc_dwords   <= nxt_cnt;
               desc_be       <= nxt_mwi ? 4'b1111 : nxt_be;
               desc_line_end <= nxt_end;
               state         <= ST_SEND;
            end
            ST_SEND: if (desc_ready) begin
               cur_addr <= cur_addr + AW'({desc_dwords, 2'b00});
               if (sent_bytes >= rem_bytes) begin
                  rem_bytes <= '0;
                  state     <= ST_DONE;
               end else begin
                  rem_bytes <= rem_bytes - sent_bytes;
                  state     <= ST_PREP;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign req_ready  = (state == ST_IDLE);
   assign desc_valid = (state == ST_SEND);
   assign done       = (state == ST_DONE);
   assign desc_cmd   = cmd_r;
endmodule

// File: rtl/dws_checker.sv
module dws_checker #(
   parameter int AW    = 32,
   parameter int CNT_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_ready,
   input logic             desc_valid,
   input logic             desc_ready,
   input logic [3:0]       desc_cmd,
   input logic [AW-1:0]    desc_addr,
   input logic [CNT_W-1:0] desc_dwords,
   input logic [3:0]       desc_be,
   input logic             desc_line_end,
   input logic             done
);
   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && !desc_ready |=> desc_valid && $stable(desc_cmd) && $stable(desc_addr)
         && $stable(desc_dwords) && $stable(desc_be) && $stable(desc_line_end));

   assert_mwi_shape_R3: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && desc_cmd == 4'b1111 |-> desc_be == 4'b1111 && desc_line_end
         && (desc_dwords == CNT_W'(8) || desc_dwords == CNT_W'(16)));

   assert_mwi_align_R2: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && desc_cmd == 4'b1111 |->
         ((desc_dwords == CNT_W'(16)) ? (desc_addr[5:2] == 4'd0) : (desc_addr[4:2] == 3'd0)));

   assert_nonzero_R4: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid |-> desc_dwords != '0);

   assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done && req_ready);

   assert_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
      desc_valid && desc_ready |=> !req_ready);
endmodule

bind dma_wr_splitter dws_checker #(.AW(AW), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/dma_wr_splitter_test.sv
module dma_wr_splitter_test;
   typedef struct packed {
      logic [3:0]  cmd;
      logic [31:0] addr;
      logic [4:0]  dw;
      logic [3:0]  be;
      logic        le;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0;
   logic        req_ready;
   logic [31:0] req_addr = '0;
   logic [15:0] req_len = '0;
   logic [7:0]  cfg_line_dw = 8'd16;
   logic [15:0] cfg_cmd = 16'h0010;
   logic [7:0]  fifo_level = 8'd64;
   logic        desc_valid;
   logic        desc_ready = 1'b0;
   logic [3:0]  desc_cmd;
   logic [31:0] desc_addr;
   logic [4:0]  desc_dwords;
   logic [3:0]  desc_be;
   logic        desc_line_end;
   logic        done;

   int   checks = 0;
   int   errors = 0;
   int   cyc = 0;
   bit   stall = 1'b0;
   bit   live = 1'b0;
   exp_t q[$];

   always #10 clk = ~clk;

   dma_wr_splitter uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_len(req_len), .cfg_line_dw(cfg_line_dw),
      .cfg_cmd(cfg_cmd), .fifo_level(fifo_level), .desc_valid(desc_valid),
      .desc_ready(desc_ready), .desc_cmd(desc_cmd), .desc_addr(desc_addr),
      .desc_dwords(desc_dwords), .desc_be(desc_be), .desc_line_end(desc_line_end),
      .done(done)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // expected bursts for constant conditions
   task automatic model(input int a0, input int len, input int ls, input bit en, input int fifo);
      bit ok = (ls == 8) || (ls == 16);
      int line = ok ? ls : 16;
      int a = a0;
      int r = len;
      while (r > 0) begin
         int off = (a / 4) % line;
         int tb = line - off;
         int rdw = (r + 3) / 4;
         int cnt = (rdw <= tb) ? rdw : tb;
         bit mwi = ok && off == 0 && r >= line * 4 && fifo >= line && en;
         exp_t e;
         e.cmd  = mwi ? 4'b1111 : 4'b0111;
         e.addr = a;
         e.dw   = 5'(cnt);
         e.be   = 4'b1111;
         if (cnt == rdw && !mwi) begin
            case (r % 4)
               1: e.be = 4'b0001;
               2: e.be = 4'b0011;
               3: e.be = 4'b0111;
               default: e.be = 4'b1111;
            endcase
         end
         e.le = (cnt == tb);
         q.push_back(e);
         if (cnt * 4 >= r) r = 0; else r = r - cnt * 4;
         a = a + cnt * 4;
      end
   endtask

   // ready pattern and scoreboard monitor
   always @(negedge clk) begin
      cyc++;
      desc_ready = stall ? 1'b0 : ((cyc % 3) != 2);
      if (live && desc_valid && desc_ready) begin
         exp_t act;
         act = {desc_cmd, desc_addr, desc_dwords, desc_be, desc_line_end};
         if (q.size() == 0) begin
            chk(1'b0, "R10 unexpected descriptor", 64'(act), 64'd0);
         end else begin
            exp_t e;
            e = q.pop_front();
            chk(act == e, "R2 R4 R5 R6 R9 descriptor", 64'(act), 64'(e));
         end
      end
   end

   task automatic send(input int a, input int len);
      @(negedge clk);
      chk(req_ready == 1'b1, "R10 ready when idle", 64'(req_ready), 64'd1);
      req_addr  = a;
      req_len   = 16'(len);
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic wait_done();
      int n = 0;
      while (!done && n < 5000) begin
         @(negedge clk);
         n++;
      end
      chk(done == 1'b1, "R8 done seen", 64'(done), 64'd1);
      chk(q.size() == 0, "R8 all bursts out before done", 64'(q.size()), 64'd0);
      @(negedge clk);
      chk(done == 1'b0, "R8 done one cycle", 64'(done), 64'd0);
   endtask

   task automatic run(input int a, input int len, input int ls, input bit en, input int fifo);
      cfg_line_dw = 8'(ls);
      cfg_cmd     = en ? 16'h0017 : 16'hFFEF;
      fifo_level  = 8'(fifo);
      model(a, len, ls, en, fifo);
      send(a, len);
      wait_done();
   endtask

   initial begin
      #(200000 * 20);
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b1 && desc_valid == 1'b0 && done == 1'b0, "R1 reset state",
          64'({req_ready, desc_valid, done}), 64'b100);
      rst_n = 1'b1;
      live  = 1'b1;
      @(negedge clk);

      // R4 misaligned head, full lines, tail; R10 busy requests ignored
      cfg_line_dw = 8'd16; cfg_cmd = 16'h0010; fifo_level = 8'd64;
      model(32'h1004, 1514, 16, 1'b1, 64);
      send(32'h1004, 1514);
      repeat (3) @(negedge clk);
      chk(req_ready == 1'b0, "R10 busy not ready", 64'(req_ready), 64'd0);
      req_addr = 32'hDEAD0; req_len = 16'd40; req_valid = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      wait_done();

      run(32'h2000, 256, 8, 1'b1, 32);   // R2 aligned, all invalidate at 8
      run(32'h2000, 256, 8, 1'b0, 32);   // R2 enable bit clear
      run(32'h2000, 64, 8, 1'b1, 7);     // R2 fifo one short
      run(32'h2010, 100, 16, 1'b1, 64);  // R4 R6 small unaligned, remainder 0
      run(32'h3000, 100, 4, 1'b1, 64);   // R5 unsupported line size
      run(32'h3008, 90, 12, 1'b1, 64);   // R5 R6 remainder 2
      run(32'h4000, 3, 16, 1'b1, 64);    // R6 remainder 3
      run(32'h4004, 1, 16, 1'b1, 64);    // R6 remainder 1
      run(32'h5000, 60, 16, 1'b1, 64);   // R2 under one line
      run(32'h6000, 0, 16, 1'b1, 64);    // R8 zero length

      // R7 stall while fifo drops: held burst unchanged, next line plain
      begin
         exp_t held;
         cfg_line_dw = 8'd8; cfg_cmd = 16'h0010; fifo_level = 8'd8;
         model(32'h400, 32, 8, 1'b1, 8);
         model(32'h420, 32, 8, 1'b1, 0);
         stall = 1'b1;
         send(32'h400, 64);
         repeat (3) @(negedge clk);
         chk(desc_valid && desc_cmd == 4'b1111, "R7 pending invalidate",
             64'({desc_valid, desc_cmd}), 64'h1F);
         held = {desc_cmd, desc_addr, desc_dwords, desc_be, desc_line_end};
         fifo_level = 8'd0;
         repeat (3) @(negedge clk);
         chk(desc_valid && ({desc_cmd, desc_addr, desc_dwords, desc_be, desc_line_end} == held),
             "R7 held stable", 64'({desc_cmd, desc_addr, desc_dwords, desc_be, desc_line_end}), 64'(held));
         stall = 1'b0;
         wait_done();
      end

      repeat (20) @(negedge clk);
      chk(q.size() == 0 && desc_valid == 1'b0, "R10 no stray bursts", 64'(q.size()), 64'd0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule